// File: doc/BRIEF.md
# Ramp-Comparator Timer Capture

This block is the digital back end of a four-channel single-slope converter. An external current source charges a capacitor, and four analog comparators watch the resulting voltage ramp, each against its own input. One shared 12-bit counter measures time along the ramp. Each channel stores the counter value at the moment its comparator output first goes high. The PWM synchronisation pulse frames every conversion. While the pulse is high, the capacitor is discharged and the counter is held at zero. Once the pulse falls, the counter runs until the next pulse.

A rate bit picks the counter speed. With the bit set, the counter advances on every clock. With the bit clear, it advances on every second clock. The bit is sampled once per conversion, when the sync pulse rises. The comparator lines are asynchronous and pass through a two-flop synchroniser before edge detection. The results of a conversion appear in the capture outputs at the next sync rising edge and hold there for the whole following period. A channel whose comparator never tripped reads zero. A per-channel status flag shows, during the counting phase, which channels have already tripped.

Control is a three-state machine inside the timer:
- IDLE holds after reset until the first sync pulse.
- RAMP_RST covers the sync pulse.
- COUNT covers the rest of the period.

Its transitions are:
- IDLE→RAMP_RST on sync high, called "arm".
- RAMP_RST→COUNT on sync low, called "release".
- COUNT→RAMP_RST on sync high, called "restart".

Both "arm" and "restart" commit the results.

Top module: `rcadc_capture`

## Requirements
- R1: After reset, every capture output and every status flag is zero and the counter is zero. Nothing is captured before the first sync pulse.
- R2: While the sync input is high, the counter is held at zero. Counting starts from zero on the clock after the pulse falls, whatever the pulse width.
- R3: With the rate bit at 1 for a conversion, the counter reaches n after n clock edges in COUNT.
- R4: With the rate bit at 0 for a conversion, the counter reaches floor(n/2) after n clock edges in COUNT. The first increment comes on the second edge.
- R5: The counter stops at 4095 and never wraps within a conversion.
- R6: A comparator input that goes high before clock edge a is synchronised over two edges. The channel stores the counter value present after edge a+1. This happens only if edge a+2 lies in COUNT with sync low.
- R7: Only the first synchronised rising edge in COUNT is stored. Later edges in the same conversion are ignored. A rise seen during the sync pulse is also ignored, even if the input then stays high.
- R8: A channel that has not tripped by the sync rising edge reports 0x000 for that conversion.
- R9: A channel's status flag rises with its capture and stays high until the sync rising edge clears every flag.
- R10: Capture outputs change only at a sync rising edge. Channel i occupies bits [12i+11:12i] of `result_o`.
- R11: The rate bit is sampled at the sync rising edge. A change during a conversion takes effect only at the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | PWM sync pulse, synchronous to clk, high = ramp reset |
| fast_i | input | 1 | Rate select: 1 = count every clock, 0 = every second clock |
| cmp_i | input | 4 | Asynchronous comparator outputs, bit i = channel i |
| result_o | output | 48 | Capture registers, 12 bits per channel, channel 0 in the low bits |
| status_o | output | 4 | Per-channel trip flag for the current conversion |

## Verification
A corrupted counter or a wrong toggle phase shows up as a capture value that is off by one or by a factor of two. It becomes visible one sync edge after the conversion in which it happened. A state machine stuck in the wrong state either freezes the outputs at zero or commits in the middle of a period, and this is caught at the next sync pulse. An edge detector that re-arms shows up as a capture taken from a later bounce rather than the first rise. A rate bit that is sampled too early shows as a halved or doubled value in the same conversion.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RAMP_RST = 2'd1,
        ST_COUNT    = 2'd2
    } phase_t;
endpackage

// File: rtl/rcadc_sync.sv
module rcadc_sync #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_i,
    output logic [NCH-1:0] rise_o
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] safe_q;
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            safe_q <= meta_q;
            prev_q <= safe_q;
        end
    end

    assign rise_o = safe_q & ~prev_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            // a detected rise lasts exactly one cycle (R6)
            p_rise_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[g] |=> !rise_o[g]);
        end
    endgenerate
endmodule

// File: rtl/rcadc_timer.sv
module rcadc_timer
    import rcadc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             fast_i,
    output logic [CNT_W-1:0] count_o,
    output logic             window_o,
    output logic             commit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             tog_q;
    logic             rate_q;
    logic             tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm, release, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (sync_i)  state_d = ST_RAMP_RST;
            ST_RAMP_RST: if (!sync_i) state_d = ST_COUNT;
            ST_COUNT:    if (sync_i)  state_d = ST_RAMP_RST;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        commit_o = 1'b0;
        window_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     commit_o = sync_i;
            ST_RAMP_RST: commit_o = 1'b0;
            ST_COUNT: begin
                commit_o = sync_i;
                window_o = !sync_i;
            end
            default:     commit_o = 1'b0;
        endcase
    end

    assign tick    = rate_q | tog_q;
    assign count_o = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            tog_q   <= 1'b0;
            rate_q  <= 1'b0;
        end else begin
            if (commit_o) rate_q <= fast_i;
            if (window_o) begin
                tog_q <= ~tog_q;
                if (tick && count_q != CNT_MAX) count_q <= count_q + 1'b1;
            end else begin
                tog_q   <= 1'b0;
                count_q <= '0;
            end
        end
    end

    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> count_q == '0);
    p_step_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && rate_q && count_q != CNT_MAX) |=> count_q == $past(count_q) + 1'b1);
    p_step_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && !rate_q && !tog_q) |=> count_q == $past(count_q));
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !sync_i) |=> count_q == CNT_MAX);
    p_rate_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |=> $stable(rate_q));
endmodule

// File: rtl/rcadc_channel.sv
module rcadc_channel #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             window_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] result_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] held_q;
    logic [CNT_W-1:0] result_q;
    logic             hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q   <= '0;
            result_q <= '0;
            hit_q    <= 1'b0;
        end else if (commit_i) begin
            result_q <= hit_q ? held_q : '0;
            hit_q    <= 1'b0;
        end else if (window_i && rise_i && !hit_q) begin
            held_q <= count_i;
            hit_q  <= 1'b1;
        end
    end

    assign result_o = result_q;
    assign hit_o    = hit_q;

    p_single_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !commit_i) |=> (hit_q && $stable(held_q)));
    p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> !hit_q);
    p_result_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(result_q));
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !hit_q) |=> result_q == '0);
endmodule

// File: rtl/rcadc_capture.sv
module rcadc_capture #(
    parameter int NCH   = 4,
    parameter int CNT_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               fast_i,
    input  logic [NCH-1:0]     cmp_i,
    output logic [NCH*CNT_W-1:0] result_o,
    output logic [NCH-1:0]     status_o
);
    logic [NCH-1:0]   rise;
    logic [CNT_W-1:0] count;
    logic             window;
    logic             commit;

    rcadc_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (cmp_i),
        .rise_o (rise)
    );

    rcadc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_i),
        .fast_i   (fast_i),
        .count_o  (count),
        .window_o (window),
        .commit_o (commit)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            rcadc_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .rise_i   (rise[g]),
                .window_i (window),
                .commit_i (commit),
                .count_i  (count),
                .result_o (result_o[g*CNT_W +: CNT_W]),
                .hit_o    (status_o[g])
            );
        end
    endgenerate

    // flags only set while counting (R9)
    p_flag_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!window && !commit) |=> ($countones(status_o) <= $countones($past(status_o))));
endmodule

// File: tb/tb_rcadc_capture.sv
module tb_rcadc_capture;
    localparam int MAXC = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic        fast_i = 1'b0;
    logic [3:0]  cmp_i = '0;
    logic [47:0] result_o;
    logic [3:0]  status_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    int d[4];
    int bounce_ch = -1;
    int early_ch = -1;
    bit cfg_fast = 1'b1;
    bit mid_fast = 1'b1;
    string tag = "R6";
    string prev_tag = "R1";
    int prev_res[4];
    bit prev_st[4];

    rcadc_capture dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .fast_i(fast_i),
        .cmp_i(cmp_i), .result_o(result_o), .status_o(status_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(bit fast, int n);
        int v = fast ? n : n / 2;
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic run_cycle(int w, int p);
        int exp_now[4];
        bit st_now[4];
        for (int i = 0; i < 4; i++) begin
            st_now[i]  = (d[i] >= 0 && d[i] <= p - 3);
            exp_now[i] = st_now[i] ? model(cfg_fast, d[i] + 1) : 0;
        end
        for (int s = 0; s < w + p; s++) begin
            @(negedge clk);
            if (s == 0)
                for (int i = 0; i < 4; i++) check("R9", int'(status_o[i]), int'(prev_st[i]));
            if (s == 1)
                for (int i = 0; i < 4; i++) begin
                    check(prev_tag, int'(result_o[i*12 +: 12]), prev_res[i]);
                    check("R9", int'(status_o[i]), 0);
                end
            sync_i = (s < w);
            fast_i = (s < w) ? cfg_fast : mid_fast;
            if (s < w) begin
                cmp_i = (early_ch >= 0) ? (4'b0001 << early_ch) : 4'b0000;
            end else begin
                for (int i = 0; i < 4; i++) if (s - w == d[i]) cmp_i[i] = 1'b1;
                if (bounce_ch >= 0) begin
                    if (s - w == d[bounce_ch] + 3) cmp_i[bounce_ch] = 1'b0;
                    if (s - w == d[bounce_ch] + 6) cmp_i[bounce_ch] = 1'b1;
                end
            end
        end
        prev_res = exp_now;
        prev_st  = st_now;
        prev_tag = tag;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin prev_res[i] = 0; prev_st[i] = 0; d[i] = -1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle toggling of comparators captures nothing
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmp_i = 4'(k);
            check("R1", int'(status_o), 0);
        end
        check("R1", int'(result_o == '0), 1);
        cmp_i = '0;
        // R3/R6 fast sweep, R4 half sweep
        for (int r = 0; r < 2; r++) begin
            cfg_fast = (r == 0);
            mid_fast = cfg_fast;
            tag = cfg_fast ? "R3" : "R4";
            for (int k = 0; k < 20; k++) begin
                d[0] = k; d[1] = k + 1; d[2] = 2 * k + 3; d[3] = (k % 3 == 0) ? -1 : 37 - k;
                run_cycle(3, 40);
            end
        end
        // R2: long pulse
        cfg_fast = 1; mid_fast = 1; tag = "R2";
        d[0] = 0; d[1] = 5; d[2] = 1; d[3] = 2;
        run_cycle(12, 20);
        // R5 saturation fast, R8 just-too-late channel
        tag = "R5";
        d[0] = 4100; d[1] = 10; d[2] = 4207; d[3] = 4208;
        run_cycle(3, 4210);
        tag = "R5";
        cfg_fast = 0; mid_fast = 0;
        d[0] = 8250; d[1] = 100; d[2] = -1; d[3] = 7;
        run_cycle(3, 8300);
        // R7: bounce and early rise
        cfg_fast = 1; mid_fast = 1; tag = "R7";
        d[0] = 4; d[1] = 9; d[2] = -1; d[3] = 2;
        bounce_ch = 0; early_ch = 2;
        run_cycle(5, 30);
        bounce_ch = -1; early_ch = -1;
        // R11: rate flips mid-conversion
        tag = "R11";
        cfg_fast = 0; mid_fast = 1;
        d[0] = 9; d[1] = 20; d[2] = 3; d[3] = -1;
        run_cycle(3, 40);
        cfg_fast = 1; mid_fast = 0;
        run_cycle(3, 40);
        // R8 / R10: empty conversion, flush previous results
        tag = "R8"; mid_fast = 1;
        for (int i = 0; i < 4; i++) d[i] = -1;
        run_cycle(3, 10);
        tag = "R10";
        run_cycle(3, 10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule